// File: doc/BRIEF.md
# Three-Level Prioritized Interrupt Controller

The controller gathers one-cycle request pulses from a set of peripheral sources and keeps each one in a sticky pending bit. Software gives each source a two-bit priority code. The code either turns the source off or places it in one of three levels. The block then offers one winning source to the CPU as a request line together with a source index. Arbitration has two tiers. The highest populated level wins first. Inside that level, the lowest source index wins.

A global enable bit gates every maskable request. Software sets or clears it through the control register. It is also cleared by reset, by a CPU acknowledge, by a trap input and by a disable command input. A separate non-maskable input is also latched. It is presented ahead of every maskable source, and the global enable does not gate it.

The CPU answers a request with a one-cycle acknowledge. The acknowledge retires the presented source. A flat register port gives software read and write access to the enable, pending and priority state.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A one-cycle pulse on `src_pulse_i[k]` sets pending bit k at the next clock edge. The bit stays set until it is cleared. If the pulse arrives in the same cycle as a software clear or an acknowledge clear of that bit, the bit ends up set.
- R2: A write to the pending register (address 1) clears every pending bit whose data bit is 0. Every pending bit whose data bit is 1 keeps its value.
- R3: The priority code of source k is held in bits [2k+1:2k] of the priority register (address 2). Code 0 disables the source. Codes 1, 2 and 3 select levels 1, 2 and 3. A disabled source still latches pulses as pending, but it never raises `irq_o`.
- R4: When a new source is selected, a pending source at a higher level always wins over any pending source at a lower level.
- R5: Among pending sources at the same level, the lowest source index wins.
- R6: Writing control register (address 0) bit 0 with 1 sets the global enable, and writing it with 0 clears it. A maskable request is shown on `irq_o` only while the global enable is set. `irq_o` falls in the same cycle in which the enable reads back as 0.
- R7: The global enable is cleared by reset, by an accepted acknowledge, by `trap_i` and by `di_i`. Each of these clear events takes precedence over a software write of 1 made in the same cycle.
- R8: An acknowledge (`ack_i` high while `irq_o` is high) clears the pending bit of the presented source and drops `irq_o` at the next edge.
- R9: `irq_idx_o` and `irq_nmi_o` stay stable for as long as `irq_o` stays high. This holds even when a higher-priority source becomes pending in the meantime.
- R10: A pulse on `nmi_i` sets a sticky non-maskable pending flag. The flag raises `irq_o` with `irq_nmi_o` high whatever the global enable holds. It wins over any maskable source pending at the same selection. Its acknowledge clears the flag.
- R11: Reads return the global enable in bit 0 of address 0, the pending bit of source k in bit k of address 1, and the priority register at address 2. Unused bits read 0, and an unused address reads 0. Reset clears all three registers.
- R12: With the enable set and the line idle, a source pulsed in cycle t appears on `irq_o` after the second clock edge that follows the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_pulse_i | input | N_SRC | One-cycle request pulses, one per source |
| nmi_i | input | 1 | Non-maskable request pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 pending, 2 priority |
| reg_wdata_i | input | 2*N_SRC | Register write data |
| reg_rdata_o | output | 2*N_SRC | Register read data for `reg_addr_i` |
| di_i | input | 1 | Disable command; clears the global enable |
| trap_i | input | 1 | Trap or illegal-instruction event; clears the global enable |
| ack_i | input | 1 | CPU acknowledge of the presented request |
| irq_o | output | 1 | Request to the CPU |
| irq_idx_o | output | $clog2(N_SRC) | Index of the presented maskable source (0 for a non-maskable request) |
| irq_nmi_o | output | 1 | The presented request is the non-maskable one |

## Verification
The directed patterns do different jobs. Sources spread over three levels are pulsed together to separate level ordering from index ordering. Same-level groups are pulsed to isolate the lowest-index rule. A higher-priority pulse arrives while a request is held, which shows that selection is frozen and not recomputed. Collisions of a pulse with a software clear, and of a set write with a clear event, show which side has precedence. Random priority maps with random pulse sets are then checked against a bench arbitration function, and the acknowledge of each winner must remove exactly that winner's pending bit.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    LVL_OFF = 2'd0,
    LVL_1   = 2'd1,
    LVL_2   = 2'd2,
    LVL_3   = 2'd3
  } lvl_e;

  localparam logic [1:0] ADDR_CTL  = 2'd0;
  localparam logic [1:0] ADDR_PEND = 2'd1;
  localparam logic [1:0] ADDR_PRIO = 2'd2;
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int N_SRC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] pulse_i,
  input  logic             sw_we_i,
  input  logic [N_SRC-1:0] sw_keep_i,
  input  logic [N_SRC-1:0] ack_clr_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] pend_q, keep_mask;

  // write of 0 clears, write of 1 keeps
  assign keep_mask = sw_we_i ? sw_keep_i : '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & keep_mask & ~ack_clr_i) | pulse_i; // set wins
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_gie_ctl.sv
module irq_gie_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic gie_o
);
  logic gie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    gie_q <= 1'b0;
    else if (clr_i) gie_q <= 1'b0;  // clear events dominate
    else if (set_i) gie_q <= 1'b1;
  end

  assign gie_o = gie_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC = 16,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]   pend_i,
  input  logic [2*N_SRC-1:0] prio_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o
);
  localparam int N_LVL = 3;

  logic [N_SRC-1:0] lvl_mask [N_LVL+1];
  logic [IDX_W-1:0] lvl_idx  [N_LVL+1];
  logic [N_LVL:0]   lvl_any;

  function automatic logic [IDX_W-1:0] lowest_set(input logic [N_SRC-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N_SRC - 1; i >= 0; i--) if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  assign lvl_mask[0] = '0;
  assign lvl_idx[0]  = '0;
  assign lvl_any[0]  = 1'b0;

  for (genvar g = 1; g <= N_LVL; g++) begin : g_lvl
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      assign lvl_mask[g][s] = pend_i[s] && (prio_i[2*s +: 2] == 2'(g));
    end
    assign lvl_any[g] = |lvl_mask[g];
    assign lvl_idx[g] = lowest_set(lvl_mask[g]);
  end

  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    if (lvl_any[LVL_3]) begin
      valid_o = 1'b1; idx_o = lvl_idx[LVL_3];
    end else if (lvl_any[LVL_2]) begin
      valid_o = 1'b1; idx_o = lvl_idx[LVL_2];
    end else if (lvl_any[LVL_1]) begin
      valid_o = 1'b1; idx_o = lvl_idx[LVL_1];
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int N_SRC = 16,
  localparam int IDX_W = $clog2(N_SRC),
  localparam int REG_W = 2 * N_SRC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_pulse_i,
  input  logic             nmi_i,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             di_i,
  input  logic             trap_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [IDX_W-1:0] irq_idx_o,
  output logic             irq_nmi_o
);
  logic [N_SRC-1:0] pend_q, ack_clr;
  logic [REG_W-1:0] prio_q;
  logic             gie_q, nmi_pend_q;
  logic             win_valid;
  logic [IDX_W-1:0] win_idx;
  logic             irq_q, sel_nmi_q;
  logic [IDX_W-1:0] sel_idx_q;
  logic             hold_ok, ack_fire;
  logic             wr_ctl, wr_pend, wr_prio;

  assign wr_ctl  = reg_we_i && (reg_addr_i == ADDR_CTL);
  assign wr_pend = reg_we_i && (reg_addr_i == ADDR_PEND);
  assign wr_prio = reg_we_i && (reg_addr_i == ADDR_PRIO);

  assign ack_fire = ack_i && irq_o;
  assign ack_clr  = (ack_fire && !sel_nmi_q) ? (N_SRC'(1) << sel_idx_q) : '0;

  irq_req_bank #(.N_SRC(N_SRC)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pulse_i   (src_pulse_i),
    .sw_we_i   (wr_pend),
    .sw_keep_i (reg_wdata_i[N_SRC-1:0]),
    .ack_clr_i (ack_clr),
    .pend_o    (pend_q)
  );

  irq_gie_ctl u_gie (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wr_ctl && reg_wdata_i[0]),
    .clr_i  ((wr_ctl && !reg_wdata_i[0]) || ack_fire || trap_i || di_i),
    .gie_o  (gie_q)
  );

  irq_arbiter #(.N_SRC(N_SRC)) u_arb (
    .pend_i  (pend_q),
    .prio_i  (prio_q),
    .valid_o (win_valid),
    .idx_o   (win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      prio_q <= '0;
    else if (wr_prio) prio_q <= reg_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       nmi_pend_q <= 1'b0;
    else if (nmi_i)                    nmi_pend_q <= 1'b1;
    else if (ack_fire && sel_nmi_q)    nmi_pend_q <= 1'b0;
  end

  // presented request stays valid only while its condition still holds
  assign hold_ok = sel_nmi_q ? nmi_pend_q
                 : (gie_q && pend_q[sel_idx_q] && (prio_q[2*sel_idx_q +: 2] != LVL_OFF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q     <= 1'b0;
      sel_nmi_q <= 1'b0;
      sel_idx_q <= '0;
    end else if (ack_fire) begin
      irq_q <= 1'b0;
    end else if (!irq_o) begin
      irq_q     <= nmi_pend_q || (gie_q && win_valid);
      sel_nmi_q <= nmi_pend_q;
      sel_idx_q <= nmi_pend_q ? '0 : win_idx;
    end
  end

  assign irq_o     = irq_q && hold_ok;
  assign irq_idx_o = sel_idx_q;
  assign irq_nmi_o = irq_o && sel_nmi_q;

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTL:  reg_rdata_o = REG_W'(gie_q);
      ADDR_PEND: reg_rdata_o = REG_W'(pend_q);
      ADDR_PRIO: reg_rdata_o = prio_q;
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
  parameter int N_SRC = 16,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] src_pulse_i,
  input logic             nmi_i,
  input logic             ack_i,
  input logic             irq_o,
  input logic [IDX_W-1:0] irq_idx_o,
  input logic             irq_nmi_o,
  input logic [N_SRC-1:0] pend_q,
  input logic             gie_q,
  input logic             nmi_pend_q
);
  a_r1_pulse_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_pulse_i != '0) |=> ((pend_q & $past(src_pulse_i)) == $past(src_pulse_i)));

  a_r6_maskable_needs_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_nmi_o) |-> gie_q);

  a_r7_ack_clears_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> !gie_q);

  a_r8_ack_drops_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> !irq_o);

  a_r9_idx_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !ack_i) |=> (!irq_o || (irq_idx_o == $past(irq_idx_o) && irq_nmi_o == $past(irq_nmi_o))));

  a_r10_nmi_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && nmi_pend_q) |=> (irq_o && irq_nmi_o));

  a_r10_nmi_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_i |=> nmi_pend_q);
endmodule

bind prio_irq_ctrl prio_irq_chk #(.N_SRC(N_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_pulse_i (src_pulse_i),
  .nmi_i       (nmi_i),
  .ack_i       (ack_i),
  .irq_o       (irq_o),
  .irq_idx_o   (irq_idx_o),
  .irq_nmi_o   (irq_nmi_o),
  .pend_q      (pend_q),
  .gie_q       (gie_q),
  .nmi_pend_q  (nmi_pend_q)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  localparam int N     = 16;
  localparam int IDX_W = $clog2(N);
  localparam int REG_W = 2 * N;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N-1:0]     src_pulse_i = '0;
  logic             nmi_i = 1'b0;
  logic             reg_we_i = 1'b0;
  logic [1:0]       reg_addr_i = 2'd0;
  logic [REG_W-1:0] reg_wdata_i = '0;
  logic [REG_W-1:0] reg_rdata_o;
  logic             di_i = 1'b0, trap_i = 1'b0, ack_i = 1'b0;
  logic             irq_o, irq_nmi_o;
  logic [IDX_W-1:0] irq_idx_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  prio_irq_ctrl #(.N_SRC(N)) dut (.*);

  task automatic cyc();
    @(posedge clk_i); #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [REG_W-1:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    cyc();
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [REG_W-1:0] d);
    reg_addr_i = a; #0.5; d = reg_rdata_o;
  endtask

  task automatic pulse(input logic [N-1:0] v);
    src_pulse_i = v; cyc(); src_pulse_i = '0;
  endtask

  task automatic ack();
    ack_i = 1'b1; cyc(); ack_i = 1'b0;
  endtask

  // bench arbitration: highest level, then lowest index
  function automatic logic [IDX_W:0] model_win(input logic [N-1:0] p, input logic [REG_W-1:0] pr);
    for (int l = 3; l >= 1; l--)
      for (int i = 0; i < N; i++)
        if (p[i] && pr[2*i +: 2] == 2'(l)) return {1'b1, IDX_W'(i)};
    return '0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [REG_W-1:0] d, pr;
    logic [N-1:0] v;
    logic [IDX_W:0] w;
    void'($urandom(32'h5eed_1234));
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();

    // reset state
    rd(2'd0, d); check("R11 reset ctl", d, 0);
    rd(2'd1, d); check("R11 reset pend", d, 0);
    rd(2'd2, d); check("R11 reset prio", d, 0);
    rd(2'd3, d); check("R11 unused addr", d, 0);
    check("R7 reset irq", 32'(irq_o), 0);

    // disabled source latches but does not raise
    wr(2'd0, 1);
    pulse(N'(1) << 5);
    cyc(); cyc();
    check("R3 disabled no irq", 32'(irq_o), 0);
    rd(2'd1, d); check("R1 pend latched", d, 32'h20);

    // write-1 keeps, write-0 clears
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); check("R2 write1 keeps", d, 32'h20);
    wr(2'd1, 0);
    rd(2'd1, d); check("R2 write0 clears", d, 0);

    // levels: src1=3, src3=1, src9=3, src12=2
    pr = (32'd3 << 2) | (32'd1 << 6) | (32'd3 << 18) | (32'd2 << 24);
    wr(2'd2, pr);
    pulse((N'(1) << 3) | (N'(1) << 9) | (N'(1) << 12));
    check("R12 not yet after first edge", 32'(irq_o), 0);
    cyc();
    check("R12 irq after second edge", 32'(irq_o), 1);
    check("R4 level3 wins", 32'(irq_idx_o), 9);

    // higher arrival does not disturb held selection
    pulse(N'(1) << 1);
    cyc();
    check("R9 idx held", 32'(irq_idx_o), 9);
    check("R9 irq held", 32'(irq_o), 1);

    ack();
    check("R8 irq drops", 32'(irq_o), 0);
    rd(2'd1, d); check("R8 bit cleared", d, 32'h100A);
    rd(2'd0, d); check("R7 ack clears gie", d, 0);
    cyc(); cyc();
    check("R6 no irq gie off", 32'(irq_o), 0);
    wr(2'd0, 1); cyc();
    check("R6 irq after enable", 32'(irq_o), 1);
    check("R4 next winner", 32'(irq_idx_o), 1);
    wr(2'd0, 0);
    check("R6 irq drops with gie", 32'(irq_o), 0);

    // same level: lowest index
    wr(2'd1, 0);
    pr = (32'd2 << 4) | (32'd2 << 14) | (32'd2 << 28);
    wr(2'd2, pr);
    pulse((N'(1) << 14) | (N'(1) << 7) | (N'(1) << 2));
    wr(2'd0, 1); cyc();
    check("R5 lowest index", 32'(irq_idx_o), 2);
    ack();
    rd(2'd1, d); check("R8 same-level bit cleared", d, 32'h4080);
    wr(2'd0, 1); cyc();
    check("R5 next index", 32'(irq_idx_o), 7);

    trap_i = 1'b1; cyc(); trap_i = 1'b0;
    check("R7 trap drops irq", 32'(irq_o), 0);
    rd(2'd0, d); check("R7 trap clears gie", d, 0);
    di_i = 1'b1; wr(2'd0, 1); di_i = 1'b0;
    rd(2'd0, d); check("R7 di beats set", d, 0);

    // pulse vs clear collision
    src_pulse_i = N'(1) << 4;
    wr(2'd1, 0);
    src_pulse_i = '0;
    rd(2'd1, d); check("R1 set beats clear", d, 32'h10);

    // non-maskable
    wr(2'd1, 0);
    nmi_i = 1'b1; cyc(); nmi_i = 1'b0; cyc();
    check("R10 nmi irq gie off", 32'(irq_o), 1);
    check("R10 nmi flag", 32'(irq_nmi_o), 1);
    ack();
    check("R10 nmi ack", 32'(irq_o), 0);
    wr(2'd2, 32'd3);
    wr(2'd0, 1);
    nmi_i = 1'b1; src_pulse_i = N'(1); cyc(); nmi_i = 1'b0; src_pulse_i = '0; cyc();
    check("R10 nmi beats level3", 32'(irq_nmi_o), 1);
    ack();
    rd(2'd0, d); check("R7 nmi ack clears gie", d, 0);
    wr(2'd0, 1); cyc();
    check("R10 maskable after nmi", 32'(irq_o), 1);
    check("R10 maskable idx", 32'(irq_idx_o), 0);
    check("R10 maskable flag", 32'(irq_nmi_o), 0);

    // random priority maps and pulse sets
    for (int it = 0; it < 300; it++) begin
      wr(2'd0, 0);
      wr(2'd1, 0);
      pr = $urandom();
      wr(2'd2, pr);
      v = N'($urandom());
      pulse(v);
      wr(2'd0, 1);
      cyc();
      w = model_win(v, pr);
      check("R4 R5 random valid", 32'(irq_o), 32'(w[IDX_W]));
      if (w[IDX_W]) begin
        check("R4 R5 random idx", 32'(irq_idx_o), 32'(w[IDX_W-1:0]));
        ack();
        rd(2'd1, d);
        check("R8 random clear", d, 32'(v & ~(N'(1) << w[IDX_W-1:0])));
      end else begin
        rd(2'd1, d);
        check("R3 random pend", d, 32'(v));
      end
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule